// File: doc/BRIEF.md
# Split-Halves Signed Fixed-Point Multiply-Accumulator

The block sums the products of a stream of 32-bit signed operand pairs, using only 16x16 unsigned multipliers and adders. A frame of pairs arrives over a valid/ready input. The first pair carries a start strobe and the final pair carries a last strobe; one pair may carry both. Each operand is cut into two unsigned 16-bit halves. Four half-by-half product sums are kept in separate accumulators.

The signed result is never formed beat by beat. Two correction sums and a both-negative count are kept next to the four product sums:
- When A is negative, the unsigned B is added to one correction sum.
- When B is negative, the unsigned A is added to the other correction sum.
- When both are negative, the count is incremented.

When the frame ends, the sums are weighted and combined into an exact 80-bit two's complement total. A 32-bit fixed-point window is taken from that total at a byte-aligned offset, and a flag marks when the window cannot hold the total.

The block suits matrix or filter engines that need 32-bit fixed-point dot products but only have half-width multipliers.

Top module: `split_mac`

## Requirements
- R1: While reset is asserted, `in_ready` and `out_valid` are 0 and `full_sum` is 0. In the first cycle after reset is released, `in_ready` is 1, and it stays 1 from then on.
- R2: A frame of one pair (start and last on the same beat) yields `full_sum` equal to the exact signed 64-bit product of the two operands, sign-extended to 80 bits. This holds for every sign combination.
- R3: Over a frame of N accepted pairs, `full_sum` equals the exact sum of the N signed products, held modulo 2^80. A beat that carries the start strobe discards everything accumulated before it.
- R4: When both operands are negative, the combined total includes the both-negative count weighted by 2^64. The product of the most negative operand with itself is therefore exactly 2^62, and 199 such terms sum to exactly 199·2^62.
- R5: `out_valid` is 1 for exactly one cycle. That cycle is the one after the clock edge that accepts a beat carrying the last strobe. At all other times `out_valid` is 0.
- R6: A cycle with `in_valid` low accepts nothing. It changes no sum, whatever values the operand and strobe inputs carry.
- R7: `fix_out` is bits LSB+31 down to LSB of the 80-bit total, where LSB = 32 − INT_BITS. With the default INT_BITS = 16 (16.16 format), this is bits 47 down to 16.
- R8: `fix_ovf` is 1 exactly when bits 79 down to LSB+32 of the total are not all equal to bit LSB+31.
- R9: After a frame ends, `full_sum`, `fix_out` and `fix_ovf` hold their values until the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block accepts a pair this cycle |
| in_start | input | 1 | This pair opens a new frame |
| in_last | input | 1 | This pair closes the frame |
| a_in | input | 32 | Signed operand A |
| b_in | input | 32 | Signed operand B |
| out_valid | output | 1 | One-cycle pulse: the frame result is ready |
| full_sum | output | 80 | Exact signed sum of products |
| fix_out | output | 32 | Fixed-point window of the sum |
| fix_ovf | output | 1 | The sum does not fit the fixed-point window |

## Verification
Single-pair frames are swept over the full cross product of a set of corner operands: zero, ±1, both extremes, values with only the low or only the high half set, and mixed-sign patterns. Each sign combination exercises a different mix of the two masked correction sums and the both-negative count, so a wrong correction weight or sign shows up in at least one pairing.

Multi-pair frames of random length, with idle cycles that carry junk on the inputs, separate correct carries between the partial accumulators from the reset-by-start and hold behaviour. A 199-term frame of most-negative squares drives the count and the high-half accumulator to their largest values and forces the overflow flag.

// File: rtl/split_mac.sv
module split_mac #(
  parameter int INT_BITS = 16,
  parameter int ACC_W    = 48,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [31:0] a_in,
  input  logic [31:0] b_in,
  output logic        out_valid,
  output logic [79:0] full_sum,
  output logic [31:0] fix_out,
  output logic        fix_ovf
);
  localparam int HW    = 16;
  localparam int RES_W = 80;
  localparam int LSB   = 32 - INT_BITS;
  localparam int TOP   = LSB + 32;

  logic          ready_q;
  logic          accept;
  logic [HW-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [31:0]   p_ll, p_hl, p_lh, p_hh, m_da, m_db;
  logic          a_neg, b_neg;

  logic [ACC_W-1:0] acc_ll, acc_hl, acc_lh, acc_hh, acc_da, acc_db;
  logic [CNT_W-1:0] cnt_s;

  assign in_ready = ready_q;
  assign accept   = in_valid & ready_q;

  assign a_lo  = a_in[HW-1:0];
  assign a_hi  = a_in[31:HW];
  assign b_lo  = b_in[HW-1:0];
  assign b_hi  = b_in[31:HW];
  assign a_neg = a_in[31];
  assign b_neg = b_in[31];

  assign p_ll = {16'b0, a_lo} * {16'b0, b_lo};
  assign p_hl = {16'b0, a_hi} * {16'b0, b_lo};
  assign p_lh = {16'b0, a_lo} * {16'b0, b_hi};
  assign p_hh = {16'b0, a_hi} * {16'b0, b_hi};
  assign m_da = a_neg ? b_in : 32'b0;
  assign m_db = b_neg ? a_in : 32'b0;

  function automatic logic [ACC_W-1:0] step(input logic [ACC_W-1:0] acc,
                                            input logic [31:0] term,
                                            input logic fresh);
    return (fresh ? '0 : acc) + ACC_W'(term);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      out_valid <= 1'b0;
      acc_ll    <= '0;
      acc_hl    <= '0;
      acc_lh    <= '0;
      acc_hh    <= '0;
      acc_da    <= '0;
      acc_db    <= '0;
      cnt_s     <= '0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept & in_last;
      if (accept) begin
        acc_ll <= step(acc_ll, p_ll, in_start);
        acc_hl <= step(acc_hl, p_hl, in_start);
        acc_lh <= step(acc_lh, p_lh, in_start);
        acc_hh <= step(acc_hh, p_hh, in_start);
        acc_da <= step(acc_da, m_da, in_start);
        acc_db <= step(acc_db, m_db, in_start);
        cnt_s  <= (in_start ? '0 : cnt_s) + CNT_W'(a_neg & b_neg);
      end
    end
  end

  logic [RES_W-1:0] w_ll, w_mid, w_hh, w_corr, w_s;

  assign w_ll   = RES_W'(acc_ll);
  assign w_mid  = (RES_W'(acc_hl) + RES_W'(acc_lh)) << HW;
  assign w_hh   = RES_W'(acc_hh) << (2 * HW);
  assign w_corr = (RES_W'(acc_da) + RES_W'(acc_db)) << (2 * HW);
  assign w_s    = RES_W'(cnt_s) << (4 * HW);

  assign full_sum = w_ll + w_mid + w_hh - w_corr + w_s;
  assign fix_out  = full_sum[LSB +: 32];
  assign fix_ovf  = !((&full_sum[RES_W-1:TOP-1]) | ~(|full_sum[RES_W-1:TOP-1]));
endmodule

// File: rtl/split_mac_chk.sv
module split_mac_chk #(
  parameter int INT_BITS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_start,
  input logic        in_last,
  input logic [31:0] a_in,
  input logic [31:0] b_in,
  input logic        out_valid,
  input logic [79:0] full_sum,
  input logic [31:0] fix_out,
  input logic        fix_ovf
);
  logic        acc;
  logic signed [63:0] prod;

  assign acc  = in_valid && in_ready;
  assign prod = $signed(a_in) * $signed(b_in);

  a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  a_r5_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> out_valid);

  a_r5_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc && in_last));

  a_r2_single_term_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_start && in_last) |=> full_sum == {{16{$past(prod[63])}}, $past(prod)});

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(full_sum) && $stable(fix_out) && $stable(fix_ovf)));
endmodule

bind split_mac split_mac_chk #(.INT_BITS(INT_BITS)) u_chk (.*);

// File: tb/test_split_mac.sv
`timescale 1ns/1ps
module test_split_mac;
  localparam int INT_BITS = 16;
  localparam int LSB = 32 - INT_BITS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_start, in_last;
  logic        in_ready, out_valid, fix_ovf;
  logic [31:0] a_in, b_in, fix_out;
  logic [79:0] full_sum;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] opa [0:255];
  logic [31:0] opb [0:255];
  logic [31:0] corner [0:9];

  always #2.5 clk = ~clk;

  split_mac #(.INT_BITS(INT_BITS)) i_split_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .full_sum(full_sum), .fix_out(fix_out), .fix_ovf(fix_ovf));

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] expect_sum(input int n);
    logic signed [79:0] s = '0;
    for (int i = 0; i < n; i++) begin
      logic signed [63:0] p;
      p = $signed(opa[i]) * $signed(opb[i]);
      s = s + {{16{p[63]}}, p};
    end
    return s;
  endfunction

  task automatic run_frame(input int n, input bit gaps);
    logic [79:0] exp, snap, top_bits;
    logic exp_ovf;
    exp = expect_sum(n);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        a_in = $urandom; b_in = $urandom;
        in_start = $urandom; in_last = $urandom;
        snap = full_sum;
        @(negedge clk);
        chk(full_sum == snap, "R6 idle cycle changed sum", full_sum, snap);
        chk(!out_valid, "R6 idle cycle raised out_valid", 80'(out_valid), 80'(0));
      end
      in_valid = 1'b1;
      a_in = opa[i]; b_in = opb[i];
      in_start = (i == 0); in_last = (i == n - 1);
      @(negedge clk);
      if (i != n - 1)
        chk(!out_valid, "R5 out_valid before last", 80'(out_valid), 80'(0));
    end
    chk(out_valid, "R5 out_valid after last", 80'(out_valid), 80'(1));
    chk(full_sum == exp, (n == 1) ? "R2 single product" : "R3 frame sum", full_sum, exp);
    chk(fix_out == exp[LSB +: 32], "R7 fixed window", 80'(fix_out), 80'(exp[LSB +: 32]));
    top_bits = $signed(exp) >>> (LSB + 31);
    exp_ovf = !(top_bits == '0 || top_bits == '1);
    chk(fix_ovf == exp_ovf, "R8 overflow flag", 80'(fix_ovf), 80'(exp_ovf));
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    a_in = $urandom; b_in = $urandom;
    @(negedge clk);
    chk(!out_valid, "R5 out_valid single pulse", 80'(out_valid), 80'(0));
    chk(full_sum == exp, "R9 result held", full_sum, exp);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h0000_FFFF;
    corner[6] = 32'hFFFF_0000; corner[7] = 32'h1234_5678;
    corner[8] = 32'hEDCB_A988; corner[9] = 32'h0001_0000;
    rst_n = 1'b0; in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1;
    a_in = 32'h8000_0000; b_in = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk(!in_ready, "R1 ready low in reset", 80'(in_ready), 80'(0));
    chk(!out_valid, "R1 valid low in reset", 80'(out_valid), 80'(0));
    chk(full_sum == '0, "R1 sum zero in reset", full_sum, '0);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R1 ready after reset", 80'(in_ready), 80'(1));

    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        opa[0] = corner[i]; opb[0] = corner[j];
        run_frame(1, 1'b0);
      end

    for (int k = 0; k < 60; k++) begin
      int n;
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) begin
        opa[i] = ($urandom % 4 == 0) ? corner[$urandom % 10] : $urandom;
        opb[i] = ($urandom % 4 == 0) ? corner[$urandom % 10] : $urandom;
      end
      run_frame(n, 1'b1);
    end

    for (int i = 0; i < 199; i++) begin
      opa[i] = 32'h8000_0000; opb[i] = 32'h8000_0000;
    end
    run_frame(199, 1'b0);
    chk(full_sum == 80'(199) << 62, "R4 both-negative count weight", full_sum, 80'(199) << 62);

    for (int i = 0; i < 199; i++) begin
      opa[i] = 32'h8000_0000; opb[i] = 32'h7FFF_FFFF;
    end
    run_frame(199, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule